// File: doc/BRIEF.md
# Two-Cycle Static RAM Bridge with Ready Countdown

This block connects a single-cycle command port to an asynchronous static RAM that needs two core clocks per access. A master pulses a read or a write for one cycle with the word address, plus the write data for a write. The bridge registers everything it needs, so the master is free the next cycle. It reports progress on a two-bit countdown, `rdyCnt`. The count tells the master how many cycles remain before the read data is available or the write is complete. Zero means the result is ready or the port is idle.

Every RAM pin is driven from a flop, so the pins can be placed in pad registers: address, write data, pad drive enable, active-low chip select, output enable and write strobe. The returned word is captured in an input register. The write strobe is re-timed on the falling clock edge. This opens the strobe half a cycle after the address becomes valid and closes it half a cycle before the address may change, which fits a write into two cycles. Reads can overlap to depth two. A new read is accepted while the previous read still shows a count of one. This gives one read result every two cycles without any extra address or data register.

Top module: `sram_rc_slave`

## Requirements
- R1: While reset is asserted and after it is released, the outputs are as follows. `rdyCnt` is 0. `ramNcs`, `ramNoe` and `ramNwe` are 1. `ramDrive` is 0. `rdData` is 0.
- R2: A read pulse accepted in cycle n has the following effects. `rdyCnt` reads 2, 1, 0 in cycles n+1, n+2 and n+3. From cycle n+1 the pins show the address with `ramNcs`=0, `ramNoe`=0 and `ramDrive`=0. In cycle n+3, `rdData` holds the RAM word at that address, sampled at the edge that starts cycle n+3.
- R3: A write pulse accepted in cycle n has the following effects. `rdyCnt` reads 1 in cycle n+1 and 0 in cycle n+2. Address and data are on the pins from cycle n+1 with `ramNcs`=0 and `ramDrive`=1. `ramNwe` is 1 at the rising edge starting n+1 and 0 at the rising edge starting n+2. The pins are released (`ramNcs`=1, `ramDrive`=0) in cycle n+3 unless a new command was accepted.
- R4: A read is also accepted in a cycle where the previous read shows `rdyCnt`=1. The new read restarts the count at 2. The previous result then appears in the next cycle and stays on `rdData` for two cycles, while the count reads 2 and then 1. Back-to-back reads complete every two cycles.
- R5: `rdData` changes only when a read result is captured. Writes and idle cycles leave it unchanged.
- R6: When a write follows a read, `ramNoe` is 1 in the cycle before `ramDrive` rises and in the cycle where it rises.
- R7: Some commands are ignored and change neither the count, the pins nor the RAM. These are a read while `rdyCnt` is 2 and a write while `rdyCnt` is not 0. When read and write are pulsed together, the read is taken and the write is ignored.
- R8: `rdPipeLevel` is constant 2 and `wrPipeLevel` is constant 1.
- R9: A write is accepted in the cycle where the previous write shows `rdyCnt`=0. Both writes land in the RAM at their own addresses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock; RAM strobe re-timed on its falling edge |
| rstN | input | 1 | Asynchronous active-low reset |
| cmdAddr | input | AW | Word address, valid with a command pulse |
| cmdWrData | input | DW | Write data, valid with a write pulse |
| cmdRd | input | 1 | Single-cycle read request |
| cmdWr | input | 1 | Single-cycle write request |
| rdData | output | DW | Last captured read result |
| rdyCnt | output | 2 | Cycles remaining to completion; 0 when done or idle |
| rdPipeLevel | output | 2 | Static read overlap depth |
| wrPipeLevel | output | 2 | Static write overlap depth |
| ramAddr | output | AW | Registered RAM address pins |
| ramDout | output | DW | Registered RAM write data |
| ramDin | input | DW | RAM data returned to the bridge |
| ramDrive | output | 1 | Pad drive enable for the data bus |
| ramNcs | output | 1 | Active-low chip select |
| ramNoe | output | 1 | Active-low output enable |
| ramNwe | output | 1 | Active-low write strobe, falling-edge register |

## Verification
The hardest case to reach is the overlapped read. In that case the address pins change on the same edge that samples the previous word. A RAM model that counts only two settled cycles then returns a poison word if the bridge samples late or lets the address move early. The bench reaches this case by pulsing the next read exactly in the cycle where the count shows 1, for a chain of three reads. It checks each result in both cycles it is meant to stay valid. The ignored commands are placed in the same busy windows, and their absence is confirmed on the address pins and by reading back the RAM.

// File: rtl/sram_rc_pkg.sv
package sram_rc_pkg;
  localparam int RD_LEVEL = 2;
  localparam int WR_LEVEL = 1;
  localparam int CNT_W    = 2;

  typedef enum logic [1:0] {
    OP_IDLE  = 2'd0,
    OP_READ  = 2'd1,
    OP_WRITE = 2'd2
  } opKind_e;

  typedef struct packed {
    logic startRd;
    logic startWr;
    logic endOp;
    logic capture;
  } seqStrobe_t;
endpackage

// File: rtl/sram_ctrl.sv
module sram_ctrl
  import sram_rc_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             cmdRd,
  input  logic             cmdWr,
  output seqStrobe_t       strobe,
  output logic [CNT_W-1:0] rdyCnt
);
  opKind_e          op;
  logic [CNT_W-1:0] cnt;
  logic             accRd, accWr, rdTail, wrTail;

  // read may overlap the last counted cycle of a previous read
  assign rdTail = (op == OP_READ)  && (cnt == CNT_W'(1));
  assign wrTail = (op == OP_WRITE) && (cnt == '0);
  assign accRd  = cmdRd && ((cnt == '0) || rdTail);
  assign accWr  = cmdWr && !cmdRd && (cnt == '0);

  always_comb begin
    strobe.startRd = accRd;
    strobe.startWr = accWr;
    strobe.capture = rdTail;
    strobe.endOp   = !accRd && !accWr && (rdTail || wrTail);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      op  <= OP_IDLE;
      cnt <= '0;
    end else if (accRd) begin
      op  <= OP_READ;
      cnt <= CNT_W'(2);
    end else if (accWr) begin
      op  <= OP_WRITE;
      cnt <= CNT_W'(1);
    end else begin
      case (op)
        OP_READ: begin
          cnt <= cnt - CNT_W'(1);
          if (cnt == CNT_W'(1)) op <= OP_IDLE;
        end
        OP_WRITE: begin
          if (cnt != '0) cnt <= cnt - CNT_W'(1);
          else           op  <= OP_IDLE;
        end
        default: cnt <= '0;
      endcase
    end
  end

  assign rdyCnt = cnt;

  p_rd_start_r2: assert property (@(posedge clk) disable iff (!rstN)
    strobe.startRd |=> (rdyCnt == CNT_W'(2)));
  p_wr_start_r3: assert property (@(posedge clk) disable iff (!rstN)
    strobe.startWr |=> (rdyCnt == CNT_W'(1)));
  p_count_step_r4: assert property (@(posedge clk) disable iff (!rstN)
    (rdyCnt == CNT_W'(2)) |=> (rdyCnt == CNT_W'(1)));
  p_idle_zero_r2: assert property (@(posedge clk) disable iff (!rstN)
    ((rdyCnt == '0) && !cmdRd && !cmdWr) |=> (rdyCnt == '0));
  p_busy_ignore_r7: assert property (@(posedge clk) disable iff (!rstN)
    (rdyCnt == CNT_W'(2)) |-> (!strobe.startRd && !strobe.startWr));
endmodule

// File: rtl/sram_datapath.sv
module sram_datapath
  import sram_rc_pkg::*;
#(
  parameter int AW = 18,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rstN,
  input  seqStrobe_t    strobe,
  input  logic [AW-1:0] cmdAddr,
  input  logic [DW-1:0] cmdWrData,
  input  logic [DW-1:0] ramDin,
  output logic [AW-1:0] ramAddr,
  output logic [DW-1:0] ramDout,
  output logic          ramDrive,
  output logic          ramNcs,
  output logic          ramNoe,
  output logic          ramNwe,
  output logic [DW-1:0] rdData
);
  logic wrPulse;

  // pad-side output registers
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ramAddr  <= '0;
      ramDout  <= '0;
      ramDrive <= 1'b0;
      ramNcs   <= 1'b1;
      ramNoe   <= 1'b1;
      wrPulse  <= 1'b0;
    end else begin
      wrPulse <= strobe.startWr;
      if (strobe.startRd || strobe.startWr) begin
        ramAddr <= cmdAddr;
        ramNcs  <= 1'b0;
      end else if (strobe.endOp) begin
        ramNcs  <= 1'b1;
      end
      if (strobe.startWr) ramDout <= cmdWrData;
      if (strobe.startRd) begin
        ramNoe   <= 1'b0;
        ramDrive <= 1'b0;
      end else if (strobe.startWr) begin
        ramNoe   <= 1'b1;
        ramDrive <= 1'b1;
      end else if (strobe.endOp) begin
        ramNoe   <= 1'b1;
        ramDrive <= 1'b0;
      end
    end
  end

  // strobe opens half a cycle after the address and closes half a cycle early
  always_ff @(negedge clk or negedge rstN) begin
    if (!rstN) ramNwe <= 1'b1;
    else       ramNwe <= ~wrPulse;
  end

  // pad-side input register
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               rdData <= '0;
    else if (strobe.capture) rdData <= ramDin;
  end

  p_read_pins_r2: assert property (@(posedge clk) disable iff (!rstN)
    strobe.startRd |=> (!ramNcs && !ramNoe && !ramDrive));
  p_nwe_window_r3: assert property (@(posedge clk) disable iff (!rstN)
    !ramNwe |-> (!ramNcs && ramDrive && ramNoe));
  p_hold_result_r5: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.capture |=> $stable(rdData));
  p_noe_gap_r6: assert property (@(posedge clk) disable iff (!rstN)
    $rose(ramDrive) |-> ($past(ramNoe) && ramNoe));
  p_one_start_r7: assert property (@(posedge clk) disable iff (!rstN)
    !(strobe.startRd && strobe.startWr));
endmodule

// File: rtl/sram_rc_slave.sv
module sram_rc_slave
  import sram_rc_pkg::*;
#(
  parameter int AW = 18,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic [AW-1:0] cmdAddr,
  input  logic [DW-1:0] cmdWrData,
  input  logic          cmdRd,
  input  logic          cmdWr,
  output logic [DW-1:0] rdData,
  output logic [1:0]    rdyCnt,
  output logic [1:0]    rdPipeLevel,
  output logic [1:0]    wrPipeLevel,
  output logic [AW-1:0] ramAddr,
  output logic [DW-1:0] ramDout,
  input  logic [DW-1:0] ramDin,
  output logic          ramDrive,
  output logic          ramNcs,
  output logic          ramNoe,
  output logic          ramNwe
);
  seqStrobe_t strobe;

  assign rdPipeLevel = 2'(RD_LEVEL);
  assign wrPipeLevel = 2'(WR_LEVEL);

  sram_ctrl u_ctrl (
    .clk    (clk),
    .rstN   (rstN),
    .cmdRd  (cmdRd),
    .cmdWr  (cmdWr),
    .strobe (strobe),
    .rdyCnt (rdyCnt)
  );

  sram_datapath #(.AW(AW), .DW(DW)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .cmdAddr   (cmdAddr),
    .cmdWrData (cmdWrData),
    .ramDin    (ramDin),
    .ramAddr   (ramAddr),
    .ramDout   (ramDout),
    .ramDrive  (ramDrive),
    .ramNcs    (ramNcs),
    .ramNoe    (ramNoe),
    .ramNwe    (ramNwe),
    .rdData    (rdData)
  );
endmodule

// File: tb/sim_sram_rc_slave.sv
`timescale 1ns/1ps
module sim_sram_rc_slave;
  localparam int AW = 8;
  localparam int DW = 32;
  localparam int DEPTH = 1 << AW;
  localparam logic [DW-1:0] POISON = 32'hBAD0_BAD0;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic [AW-1:0] cmdAddr = '0;
  logic [DW-1:0] cmdWrData = '0;
  logic          cmdRd = 1'b0;
  logic          cmdWr = 1'b0;
  logic [DW-1:0] rdData;
  logic [1:0]    rdyCnt, rdPipeLevel, wrPipeLevel;
  logic [AW-1:0] ramAddr;
  logic [DW-1:0] ramDout, ramDin;
  logic          ramDrive, ramNcs, ramNoe, ramNwe;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [DW-1:0] mem    [DEPTH];
  logic [DW-1:0] shadow [DEPTH];
  logic [AW-1:0] prevAddr = '0;
  int            stab = 0;

  always #2 clk = ~clk;

  sram_rc_slave #(.AW(AW), .DW(DW)) u0 (
    .clk(clk), .rstN(rstN), .cmdAddr(cmdAddr), .cmdWrData(cmdWrData),
    .cmdRd(cmdRd), .cmdWr(cmdWr), .rdData(rdData), .rdyCnt(rdyCnt),
    .rdPipeLevel(rdPipeLevel), .wrPipeLevel(wrPipeLevel),
    .ramAddr(ramAddr), .ramDout(ramDout), .ramDin(ramDin),
    .ramDrive(ramDrive), .ramNcs(ramNcs), .ramNoe(ramNoe), .ramNwe(ramNwe)
  );

  // RAM model: data only after two settled cycles of select, enable and address
  always @(negedge clk) begin
    if (ramNcs === 1'b0 && ramNoe === 1'b0)
      stab = (ramAddr == prevAddr && stab > 0) ? stab + 1 : 1;
    else
      stab = 0;
    prevAddr = ramAddr;
  end
  assign ramDin = (stab >= 2) ? mem[ramAddr] : POISON;

  always @(posedge ramNwe) begin
    if (ramNcs === 1'b0 && ramDrive === 1'b1) mem[ramAddr] = ramDout;
  end

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic rdOp(input logic [AW-1:0] a);
    cmdRd = 1'b1; cmdAddr = a;
    step();
    cmdRd = 1'b0;
    chk("R2 count2", 64'(rdyCnt), 64'd2);
    chk("R2 oe", 64'(ramNoe), 64'd0);
    step();
    chk("R2 count1", 64'(rdyCnt), 64'd1);
    step();
    chk("R2 count0", 64'(rdyCnt), 64'd0);
    chk("R2 data", 64'(rdData), 64'(shadow[a]));
  endtask

  task automatic wrOp(input logic [AW-1:0] a, input logic [DW-1:0] d);
    chk("R6 oe off at issue", 64'(ramNoe), 64'd1);
    cmdWr = 1'b1; cmdAddr = a; cmdWrData = d;
    step();
    cmdWr = 1'b0;
    shadow[a] = d;
    chk("R3 count1", 64'(rdyCnt), 64'd1);
    chk("R3 pins", {ramAddr, ramDout, ramDrive, ramNcs, ramNwe}, {a, d, 1'b1, 1'b0, 1'b1});
    chk("R6 oe off with drive", 64'(ramNoe), 64'd1);
    step();
    chk("R3 count0", 64'(rdyCnt), 64'd0);
    chk("R3 strobe low", 64'(ramNwe), 64'd0);
    step();
    chk("R3 release", {ramNcs, ramDrive, ramNwe}, 3'b101);
  endtask

  // {isWrite, addr, data}
  localparam logic [40:0] VEC [8] = '{
    {1'b0, 8'h03, 32'h0},
    {1'b1, 8'h03, 32'h1234_5678},
    {1'b0, 8'h03, 32'h0},
    {1'b0, 8'hFF, 32'h0},
    {1'b1, 8'h00, 32'hFFFF_FFFF},
    {1'b1, 8'h80, 32'h0000_0001},
    {1'b0, 8'h00, 32'h0},
    {1'b0, 8'h80, 32'h0}
  };

  initial begin
    for (int i = 0; i < DEPTH; i++) begin
      mem[i]    = (32'(i) * 32'h0101_0101) ^ 32'hA5A5_0000;
      shadow[i] = mem[i];
    end
    step(); step();
    chk("R1 reset", {rdyCnt, ramNcs, ramNoe, ramNwe, ramDrive}, {2'd0, 4'b1110});
    chk("R1 rdData", 64'(rdData), 64'd0);
    rstN = 1'b1;
    step();
    chk("R1 after release", {rdyCnt, ramNcs, ramNoe, ramNwe, ramDrive}, {2'd0, 4'b1110});
    chk("R8 levels", {rdPipeLevel, wrPipeLevel}, 4'b1001);

    for (int v = 0; v < 8; v++) begin
      if (VEC[v][40]) wrOp(VEC[v][39:32], VEC[v][31:0]);
      else            rdOp(VEC[v][39:32]);
    end

    // R4: chained overlapped reads
    cmdRd = 1'b1; cmdAddr = 8'h10;
    step(); cmdRd = 1'b0;
    step();
    chk("R4 first count1", 64'(rdyCnt), 64'd1);
    cmdRd = 1'b1; cmdAddr = 8'h11;
    step(); cmdRd = 1'b0;
    chk("R4 restart", 64'(rdyCnt), 64'd2);
    chk("R4 data a0 first", 64'(rdData), 64'(shadow[8'h10]));
    step();
    chk("R4 data a0 second", 64'(rdData), 64'(shadow[8'h10]));
    cmdRd = 1'b1; cmdAddr = 8'h12;
    step(); cmdRd = 1'b0;
    chk("R4 data a1 first", 64'(rdData), 64'(shadow[8'h11]));
    step();
    chk("R4 data a1 second", 64'(rdData), 64'(shadow[8'h11]));
    step();
    chk("R4 last count0", 64'(rdyCnt), 64'd0);
    chk("R4 data a2", 64'(rdData), 64'(shadow[8'h12]));

    // R6 and R5: write right after read, then idle
    rdOp(8'h20);
    wrOp(8'h21, 32'hCAFE_F00D);
    step(); step(); step();
    chk("R5 hold", 64'(rdData), 64'(shadow[8'h20]));

    // R7: ignored commands
    cmdRd = 1'b1; cmdAddr = 8'h30;
    step();
    cmdAddr = 8'h31;
    step(); cmdRd = 1'b0;
    chk("R7 rd at 2 count", 64'(rdyCnt), 64'd1);
    chk("R7 rd at 2 addr", 64'(ramAddr), 64'h30);
    cmdWr = 1'b1; cmdAddr = 8'h32; cmdWrData = 32'h1111_2222;
    step(); cmdWr = 1'b0;
    chk("R7 wr busy count", 64'(rdyCnt), 64'd0);
    chk("R7 wr busy drive", 64'(ramDrive), 64'd0);
    chk("R7 result", 64'(rdData), 64'(shadow[8'h30]));
    step();
    cmdRd = 1'b1; cmdWr = 1'b1; cmdAddr = 8'h33; cmdWrData = 32'h3333_4444;
    step(); cmdRd = 1'b0; cmdWr = 1'b0;
    chk("R7 both read wins", {rdyCnt, ramDrive}, {2'd2, 1'b0});
    step(); step();
    chk("R7 both data", 64'(rdData), 64'(shadow[8'h33]));
    rdOp(8'h32);
    rdOp(8'h33);

    // R9: back-to-back writes
    cmdWr = 1'b1; cmdAddr = 8'h40; cmdWrData = 32'h0A0A_0A0A;
    step(); cmdWr = 1'b0; shadow[8'h40] = 32'h0A0A_0A0A;
    step();
    chk("R9 first count0", 64'(rdyCnt), 64'd0);
    cmdWr = 1'b1; cmdAddr = 8'h41; cmdWrData = 32'h5050_5050;
    step(); cmdWr = 1'b0; shadow[8'h41] = 32'h5050_5050;
    chk("R9 second accepted", {rdyCnt, ramAddr}, {2'd1, 8'h41});
    step(); step();
    rdOp(8'h40);
    rdOp(8'h41);

    if (!done) begin
      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    #400000;
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule